// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit for two 8-bit operands. A 3-bit operation code chooses one of eight functions: three bitwise logic operations, addition, subtraction, and three signed comparisons. The block returns an 8-bit result and four status flags: carry, zero, negative and overflow. There is no clock and no state, so the outputs follow the inputs after the gate delay.

The datapath is built from gate primitives only. A ripple chain of one-bit full adders does the arithmetic. Subtraction uses the same chain: the second operand is inverted and a carry-in of one is injected. The comparisons read the sign and overflow of that difference and do not use a separate comparator.

A small decoder turns the operation code into a bundle of strobes. The strobes are a one-hot result select, an operand-invert/carry-in control, and an enable for the arithmetic flags. The result is picked bit by bit through and-or selectors. The zero and negative flags are then taken from the selected result.

Top module: `alu8`

## Requirements
- R1: Opcode 0 (binary 000) gives the bitwise AND of the operands, opcode 1 (001) the bitwise OR, and opcode 2 (010) the bitwise XOR.
- R2: Opcode 3 (011) gives the sum of the operands modulo 256 with a carry-in of zero. The carry flag is the carry leaving bit 7, so 0xFF plus 0x01 gives 0x00 with the carry flag set.
- R3: Opcode 4 (100) gives opA minus opB modulo 256, formed as opA plus the inverse of opB plus one. The carry flag is the carry leaving bit 7 of that sum, so it is 1 exactly when opA is greater than or equal to opB as unsigned numbers.
- R4: For opcodes 3 and 4, the overflow flag is the XOR of the carry into bit 7 and the carry out of bit 7. It is set exactly when the two's complement result has the wrong sign.
- R5: Opcodes 5 (101), 6 (110) and 7 (111) compare the operands as signed two's complement numbers for equal, greater-than and less-than. The result is 0x01 when the comparison is true and 0x00 when it is false.
- R6: For every opcode other than 3 and 4, the carry and overflow flags are 0.
- R7: For every opcode, the zero flag is 1 exactly when the 8-bit result is 0x00. For a comparison this means the comparison is false.
- R8: For every opcode, the negative flag equals bit 7 of the result. It is therefore always 0 for the comparisons.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| opCode | input | 3 | Operation select |
| result | output | 8 | Selected result |
| carryOut | output | 1 | Carry flag, arithmetic opcodes only |
| zeroFlag | output | 1 | Result is all zeros |
| negFlag | output | 1 | Bit 7 of the result |
| overflowFlag | output | 1 | Signed overflow, arithmetic opcodes only |

## Verification
Every pair of operands is applied under every opcode, and the result and each flag are compared against a plain integer model. The full sweep includes several patterns that matter:
- Carries that ripple through all eight bits (0xFF plus 0x01) show whether the carry chain and the carry-in choice are right.
- Operands with equal and with opposite signs at the 0x7F/0x80 boundary separate a correct overflow from one that only looks at the top bit.
- Pairs that differ only in sign show whether the comparisons read signed rather than unsigned order.
- Equal operands show whether the equality and greater-than outputs are mutually exclusive.

A few named corner vectors are also checked before the sweep.

// File: rtl/alu8Pkg.sv
`timescale 1ns/1ps
package alu8Pkg;
  localparam int OP_W    = 3;
  localparam int NUM_OPS = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_EQ  = 3'd5,
    OP_GT  = 3'd6,
    OP_LT  = 3'd7
  } aluOp_e;

  // Strobes from the opcode decoder to the gate-level datapath
  typedef struct packed {
    logic [NUM_OPS-1:0] selHot;     // one-hot result select
    logic               invertB;    // invert opB and inject carry-in of one
    logic               arithFlags; // pass carry and overflow to the ports
  } aluStrobes_t;
endpackage

// File: rtl/alu8Control.sv
`timescale 1ns/1ps
module alu8Control
  import alu8Pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes
);
  always_comb begin
    strobes.selHot         = '0;
    strobes.selHot[opCode] = 1'b1;
    strobes.invertB        = (opCode == OP_SUB) || (opCode == OP_EQ) ||
                             (opCode == OP_GT)  || (opCode == OP_LT);
    strobes.arithFlags     = (opCode == OP_ADD) || (opCode == OP_SUB);
  end
endmodule

// File: rtl/alu8FullAdder.sv
`timescale 1ns/1ps
module alu8FullAdder (
  input  wire x,
  input  wire y,
  input  wire cin,
  output wire s,
  output wire cout
);
  wire prop;
  wire gen;
  wire pass;

  xor gP (prop, x, y);
  xor gS (s, prop, cin);
  and gG (gen, x, y);
  and gT (pass, prop, cin);
  or  gC (cout, gen, pass);
endmodule

// File: rtl/alu8MuxBit.sv
`timescale 1ns/1ps
module alu8MuxBit #(
  parameter int N = 8
) (
  input  wire [N-1:0] sel,
  input  wire [N-1:0] din,
  output wire         y
);
  wire [N-1:0] terms;
  wire [N-1:0] chain;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : gTerm
      and gA (terms[k], sel[k], din[k]);
      if (k == 0) begin : gFirst
        buf gB (chain[k], terms[k]);
      end else begin : gRest
        or gO (chain[k], chain[k-1], terms[k]);
      end
    end
  endgenerate

  buf gY (y, chain[N-1]);
endmodule

// File: rtl/alu8Datapath.sv
`timescale 1ns/1ps
module alu8Datapath
  import alu8Pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  wire [WIDTH-1:0] opA,
  input  wire [WIDTH-1:0] opB,
  input  aluStrobes_t     strobes,
  output wire [WIDTH-1:0] result,
  output wire             carryOut,
  output wire             zeroFlag,
  output wire             negFlag,
  output wire             overflowFlag
);
  localparam int MSB = WIDTH - 1;

  wire [WIDTH-1:0] andV;
  wire [WIDTH-1:0] orV;
  wire [WIDTH-1:0] xorV;
  wire [WIDTH-1:0] bEff;
  wire [WIDTH-1:0] sumV;
  wire [WIDTH:0]   carry;
  wire [WIDTH-1:0] sumOr;
  wire [WIDTH-1:0] resOr;
  wire             ovfRaw;
  wire             sumZero;
  wire             ltBit;
  wire             gtBit;
  wire             invB;
  wire             arithEn;
  wire [NUM_OPS-1:0] selHot;

  assign invB    = strobes.invertB;
  assign arithEn = strobes.arithFlags;
  assign selHot  = strobes.selHot;

  buf gCin (carry[0], invB);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : gBit
      and gAnd (andV[i], opA[i], opB[i]);
      or  gOr  (orV[i],  opA[i], opB[i]);
      xor gXor (xorV[i], opA[i], opB[i]);
      xor gInv (bEff[i], opB[i], invB);

      alu8FullAdder uFa (
        .x   (opA[i]),
        .y   (bEff[i]),
        .cin (carry[i]),
        .s   (sumV[i]),
        .cout(carry[i+1])
      );

      if (i == 0) begin : gOrFirst
        buf gS (sumOr[i], sumV[i]);
        buf gR (resOr[i], result[i]);
      end else begin : gOrNext
        or gS (sumOr[i], sumOr[i-1], sumV[i]);
        or gR (resOr[i], resOr[i-1], result[i]);
      end
    end
  endgenerate

  // Signed comparison from the difference flags
  xor gOvf (ovfRaw, carry[WIDTH], carry[WIDTH-1]);
  not gEq  (sumZero, sumOr[MSB]);
  xor gLt  (ltBit, sumV[MSB], ovfRaw);
  nor gGt  (gtBit, ltBit, sumZero);

  // Per-bit result selection
  generate
    for (i = 0; i < WIDTH; i++) begin : gSel
      wire [NUM_OPS-1:0] cand;
      if (i == 0) begin : gLow
        assign cand = {ltBit, gtBit, sumZero, sumV[i], sumV[i],
                       xorV[i], orV[i], andV[i]};
      end else begin : gHigh
        assign cand = {3'b000, sumV[i], sumV[i], xorV[i], orV[i], andV[i]};
      end
      alu8MuxBit #(.N(NUM_OPS)) uMux (
        .sel(selHot),
        .din(cand),
        .y  (result[i])
      );
    end
  endgenerate

  // Flags
  not gZ (zeroFlag, resOr[MSB]);
  buf gN (negFlag, result[MSB]);
  and gC (carryOut, carry[WIDTH], arithEn);
  and gV (overflowFlag, ovfRaw, arithEn);
endmodule

// File: rtl/alu8.sv
`timescale 1ns/1ps
module alu8
  import alu8Pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  opCode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             overflowFlag
);
  aluStrobes_t strobes;

  alu8Control uCtl (
    .opCode (opCode),
    .strobes(strobes)
  );

  alu8Datapath #(.WIDTH(WIDTH)) uDp (
    .opA         (opA),
    .opB         (opB),
    .strobes     (strobes),
    .result      (result),
    .carryOut    (carryOut),
    .zeroFlag    (zeroFlag),
    .negFlag     (negFlag),
    .overflowFlag(overflowFlag)
  );
endmodule

// File: rtl/alu8Checker.sv
`timescale 1ns/1ps
module alu8Checker
  import alu8Pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [OP_W-1:0]  opCode,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             zeroFlag,
  input logic             negFlag,
  input logic             overflowFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wideSum;
  logic           known;

  always_comb begin
    wideSum = {1'b0, opA} + {1'b0, opB};
    known   = !$isunknown({opA, opB, opCode, result, carryOut,
                           zeroFlag, negFlag, overflowFlag});
    if (known) begin
      if (opCode == OP_ADD) begin
        p_add_sum_r2: assert ({carryOut, result} == wideSum);
        p_add_ovf_r4: assert (overflowFlag ==
          ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB])));
      end
      if (opCode == OP_SUB) begin
        p_sub_carry_r3: assert (carryOut == (opA >= opB));
        p_sub_ovf_r4: assert (overflowFlag ==
          ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])));
      end
      if (opCode >= OP_EQ) begin
        p_cmp_binary_r5: assert (result[WIDTH-1:1] == '0);
      end
      if ((opCode != OP_ADD) && (opCode != OP_SUB)) begin
        p_no_overflow_r6: assert (!overflowFlag && !carryOut);
      end
      p_zero_r7: assert (zeroFlag == (result == '0));
      p_neg_r8: assert (negFlag == result[MSB]);
    end
  end
endmodule

bind alu8 alu8Checker #(.WIDTH(WIDTH)) uChk (
  .opA         (opA),
  .opB         (opB),
  .opCode      (opCode),
  .result      (result),
  .carryOut    (carryOut),
  .zeroFlag    (zeroFlag),
  .negFlag     (negFlag),
  .overflowFlag(overflowFlag)
);

// File: tb/tb_alu8.sv
`timescale 1ns/1ps
module tb_alu8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [2:0] opCode = 3'd0;
  logic [7:0] result;
  logic       carryOut;
  logic       zeroFlag;
  logic       negFlag;
  logic       overflowFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu8 dut (
    .opA         (opA),
    .opB         (opB),
    .opCode      (opCode),
    .result      (result),
    .carryOut    (carryOut),
    .zeroFlag    (zeroFlag),
    .negFlag     (negFlag),
    .overflowFlag(overflowFlag)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
      finishRun();
    end
  end

  task automatic check(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h: actual %0h expected %0h",
               tag, what, opCode, opA, opB, actual, expected);
    end
  endtask

  // Behavioural reference: returns {carry, overflow, zero, neg, result}
  function automatic logic [11:0] refModel(int op, int x, int y);
    int r = 0;
    int c = 0;
    int v = 0;
    int sx = (x > 127) ? x - 256 : x;
    int sy = (y > 127) ? y - 256 : y;
    int t;
    case (op)
      0: r = x & y;
      1: r = x | y;
      2: r = x ^ y;
      3: begin
        t = x + y;
        r = t % 256;
        c = (t > 255) ? 1 : 0;
        v = ((x / 128) == (y / 128) && (r / 128) != (x / 128)) ? 1 : 0;
      end
      4: begin
        t = x + (255 - y) + 1;
        r = t % 256;
        c = (t > 255) ? 1 : 0;
        v = ((x / 128) != (y / 128) && (r / 128) != (x / 128)) ? 1 : 0;
      end
      5: r = (sx == sy) ? 1 : 0;
      6: r = (sx > sy) ? 1 : 0;
      default: r = (sx < sy) ? 1 : 0;
    endcase
    refModel = {c[0], v[0], (r == 0), r[7], r[7:0]};
  endfunction

  function automatic string resTag(int op);
    if (op <= 2) return "R1";
    if (op == 3) return "R2";
    if (op == 4) return "R3";
    return "R5";
  endfunction

  // Drive one vector, wait half a nanosecond, compare everything
  task automatic applyVec(int op, int x, int y);
    logic [11:0] e;
    bit arith;
    opCode = op[2:0];
    opA    = x[7:0];
    opB    = y[7:0];
    #0.5;
    e = refModel(op, x, y);
    arith = (op == 3) || (op == 4);
    check(resTag(op), "result", int'(result), int'(e[7:0]));
    check(arith ? ((op == 3) ? "R2" : "R3") : "R6", "carry",
          int'(carryOut), int'(e[11]));
    check(arith ? "R4" : "R6", "overflow", int'(overflowFlag), int'(e[10]));
    check("R7", "zero", int'(zeroFlag), int'(e[9]));
    check("R8", "neg", int'(negFlag), int'(e[8]));
    #0.5;
  endtask

  initial begin
    #0.25;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.25;
    // Idle inputs: AND of zeros gives zero result with zero flag (R1, R7)
    applyVec(0, 0, 0);
    // Named corners
    applyVec(3, 8'hFF, 8'h01); // R2 full ripple, carry set, zero set
    applyVec(3, 8'h7F, 8'h01); // R4 positive overflow
    applyVec(4, 8'h80, 8'h01); // R4 negative overflow on subtract
    applyVec(4, 8'h00, 8'h01); // R3 borrow: carry clear, result FF
    applyVec(4, 8'h55, 8'h55); // R3 equal operands: carry set
    applyVec(7, 8'h80, 8'h7F); // R5 signed less-than across sign
    applyVec(6, 8'h7F, 8'h80); // R5 signed greater-than across sign
    applyVec(5, 8'hA5, 8'hA5); // R5 equal
    applyVec(6, 8'h33, 8'h33); // R5 equal is not greater, zero set (R7)
    applyVec(2, 8'hF0, 8'h0F); // R1 xor, negative (R8)
    // Exhaustive sweep
    for (int op = 0; op < 8; op++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          applyVec(op, x, y);
        end
      end
    end
    finishRun();
  end
endmodule